// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block decides whether one local interrupt unit is a target of an inter-processor message. It combines the message's destination byte, its addressing mode (physical or logical) and its shorthand code with the unit's own identity registers, and produces a single match bit. Logical addressing supports two formats, flat and cluster, which are chosen by a format register. An unknown format value gives no match and raises an error flag.

The block also holds the unit's addressing registers, and masks each write to them. It contains a lowest-priority selector. The selector takes a bitmap of units that matched and a bitmap of units that are enabled, and picks one eligible unit in rotating order. The result appears one cycle after the request. Delivering the message is left to the surrounding logic.

Top module: `ipi_target_matcher`

## Requirements
- R1: With shorthand code 0 and physical mode (`msg_logical`=0), `match_o` is 1 exactly when `msg_dest` is 0xFF or equals `id_q[31:24]`.
- R2: With shorthand code 0, logical mode and `fmt_q[31:28]`=0xF (flat), `match_o` is 1 exactly when `lgc_q[31:24] & msg_dest` is nonzero.
- R3: With shorthand code 0, logical mode and `fmt_q[31:28]`=0x0 (cluster), `match_o` is 1 exactly when the upper nibbles of `lgc_q[31:24]` and `msg_dest` are equal and the AND of their lower nibbles is nonzero.
- R4: Shorthand code 1 (self) matches only when `is_sender` is 1. Code 2 (all including self) always matches. Code 3 (all excluding self) matches only when `is_sender` is 0. Destination, mode and format have no effect under any of these codes.
- R5: With shorthand code 0, logical mode and `fmt_q[31:28]` equal to neither 0xF nor 0x0, `match_o` is 0 and `fmt_err_o` is 1. In every other case `fmt_err_o` is 0.
- R6: A write with `wr_en`=1 takes effect on the next clock edge. The target register is chosen by `wr_sel`: 0 selects ID, 1 selects logical, 2 selects format and 3 selects command-high. ID, logical and command-high keep only `wr_data[31:24]` and clear bits 23:0. Format stores `wr_data` with bits 27:0 forced to one.
- R7: When `sel_req` is 1 at a clock edge, the selector searches from the unit after the last one chosen, wrapping past N-1 to 0 and coming back to the last chosen unit itself. On the following cycle it drives `sel_valid_o`=1 and `sel_idx_o` set to the first eligible unit, and it records that unit as the new last choice.
- R8: A unit is eligible only when its bit is set in both `cand_map` and `unit_en`. If no unit is eligible, `sel_none_o`=1 and `sel_valid_o`=0 for one cycle, and the last choice is left unchanged.
- R9: After reset, `id_q`, `lgc_q` and `cmdhi_q` are 0 and `fmt_q` is 0xFFFFFFFF. `sel_valid_o` and `sel_none_o` are 0. The first search starts at unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 ID, 1 logical, 2 format, 3 command-high |
| wr_data | input | 32 | Write data |
| id_q | output | 32 | Unit ID register |
| lgc_q | output | 32 | Logical ID register |
| fmt_q | output | 32 | Logical format register |
| cmdhi_q | output | 32 | Command-high register |
| msg_dest | input | 8 | Message destination byte |
| msg_logical | input | 1 | 0 physical, 1 logical addressing |
| msg_short | input | 2 | Shorthand: 0 none, 1 self, 2 all incl, 3 all excl |
| is_sender | input | 1 | This unit issued the message |
| match_o | output | 1 | This unit is a target |
| fmt_err_o | output | 1 | Logical addressing with unknown format |
| sel_req | input | 1 | Start a lowest-priority selection |
| cand_map | input | N_UNITS | Units that matched the message |
| unit_en | input | N_UNITS | Units that are enabled |
| sel_valid_o | output | 1 | Selection found (one cycle) |
| sel_none_o | output | 1 | No eligible unit (one cycle) |
| sel_idx_o | output | clog2(N_UNITS) | Selected unit index |

## Verification
`match_o` and `fmt_err_o` are combinational, so they are due in the same cycle as the message inputs. The bench drives those inputs on a falling edge and samples them shortly afterwards. A register write appears on the outputs after the next rising edge, so the bench reads it back on the falling edge that follows. Each selector result is due exactly one rising edge after `sel_req`, and the bench samples it on the next falling edge. At that point the bench has already computed the expected index by stepping its own pointer around the ring.

// File: rtl/ipi_match_pkg.sv
package ipi_match_pkg;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_SELF = 2'd1,
    SH_ALL  = 2'd2,
    SH_OTHR = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    RS_ID    = 2'd0,
    RS_LGC   = 2'd1,
    RS_FMT   = 2'd2,
    RS_CMDHI = 2'd3
  } regsel_e;

  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  function automatic logic [31:0] keep_top_byte(input logic [31:0] v);
    return {v[31:24], 24'h0};
  endfunction

  function automatic logic [31:0] fmt_fill(input logic [31:0] v);
    return v | 32'h0FFF_FFFF;
  endfunction

  function automatic logic flat_hit(input logic [7:0] lid, input logic [7:0] d);
    return (lid & d) != 8'h0;
  endfunction

  function automatic logic cluster_hit(input logic [7:0] lid, input logic [7:0] d);
    return (lid[7:4] == d[7:4]) && ((lid[3:0] & d[3:0]) != 4'h0);
  endfunction

endpackage

// File: rtl/target_regs.sv
module target_regs
  import ipi_match_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] id_q,
  output logic [31:0] lgc_q,
  output logic [31:0] fmt_q,
  output logic [31:0] cmdhi_q
);

  logic wr_id, wr_lgc, wr_fmt, wr_cmdhi;
  assign wr_id    = wr_en && (wr_sel == RS_ID);
  assign wr_lgc   = wr_en && (wr_sel == RS_LGC);
  assign wr_fmt   = wr_en && (wr_sel == RS_FMT);
  assign wr_cmdhi = wr_en && (wr_sel == RS_CMDHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      lgc_q   <= '0;
      fmt_q   <= '1;
      cmdhi_q <= '0;
    end else begin
      if (wr_id)    id_q    <= keep_top_byte(wr_data);
      if (wr_lgc)   lgc_q   <= keep_top_byte(wr_data);
      if (wr_fmt)   fmt_q   <= fmt_fill(wr_data);
      if (wr_cmdhi) cmdhi_q <= keep_top_byte(wr_data);
    end
  end

  // R6
  fmt_low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_fmt) |-> (fmt_q[27:0] == 28'hFFF_FFFF));

  // R6
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_id) |-> $stable(id_q));

endmodule

// File: rtl/dest_match.sv
module dest_match
  import ipi_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] dest,
  input  logic       logical_mode,
  input  logic [1:0] short_code,
  input  logic       is_sender,
  input  logic [7:0] unit_id,
  input  logic [7:0] logical_id,
  input  logic [3:0] fmt_model,
  output logic       match,
  output logic       fmt_err
);

  logic phys_hit, flat_ok, clus_ok, logic_hit, bad_fmt;

  assign phys_hit = (dest == 8'hFF) || (dest == unit_id);
  assign flat_ok  = (fmt_model == FMT_FLAT)    && flat_hit(logical_id, dest);
  assign clus_ok  = (fmt_model == FMT_CLUSTER) && cluster_hit(logical_id, dest);
  assign bad_fmt  = (fmt_model != FMT_FLAT) && (fmt_model != FMT_CLUSTER);
  assign logic_hit = flat_ok || clus_ok;

  always_comb begin
    match   = 1'b0;
    fmt_err = 1'b0;
    unique case (short_code)
      SH_NONE: begin
        if (!logical_mode) match = phys_hit;
        else begin
          match   = logic_hit;
          fmt_err = bad_fmt;
        end
      end
      SH_SELF: match = is_sender;
      SH_ALL:  match = 1'b1;
      SH_OTHR: match = !is_sender;
      default: match = 1'b0;
    endcase
  end

  // R5
  fmt_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !match);

  // R1
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_code == SH_NONE && !logical_mode && dest == 8'hFF) |-> match);

  // R4
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_code == SH_SELF) |-> (match == is_sender));

  // R4
  all_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_code == SH_ALL) |-> (match && !fmt_err));

endmodule

// File: rtl/rr_lowest_sel.sv
module rr_lowest_sel #(
  parameter int N_UNITS = 16,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_req,
  input  logic [N_UNITS-1:0] cand_map,
  input  logic [N_UNITS-1:0] unit_en,
  output logic               sel_valid_o,
  output logic               sel_none_o,
  output logic [IW-1:0]      sel_idx_o
);

  localparam logic [IW-1:0] LAST_RST = IW'(N_UNITS - 1);

  function automatic logic [IW:0] scan_from(input logic [IW-1:0] last,
                                            input logic [N_UNITS-1:0] elig);
    logic [IW:0] r;
    r = '0;
    for (int k = N_UNITS; k >= 1; k--) begin
      int p;
      p = (int'(last) + k) % N_UNITS;
      if (elig[p]) r = {1'b1, IW'(p)};
    end
    return r;
  endfunction

  logic [IW-1:0]      last_q;
  logic [N_UNITS-1:0] elig;
  logic [IW:0]        scan;
  logic               found;

  assign elig  = cand_map & unit_en;
  assign scan  = scan_from(last_q, elig);
  assign found = scan[IW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q      <= LAST_RST;
      sel_valid_o <= 1'b0;
      sel_none_o  <= 1'b0;
      sel_idx_o   <= '0;
    end else begin
      sel_valid_o <= sel_req && found;
      sel_none_o  <= sel_req && !found;
      if (sel_req && found) begin
        last_q    <= scan[IW-1:0];
        sel_idx_o <= scan[IW-1:0];
      end
    end
  end

  // R8
  pick_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid_o |-> ((($past(elig)) >> sel_idx_o) & N_UNITS'(1)) != '0);

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid_o || sel_none_o) |-> $past(sel_req));

  // R8
  valid_none_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid_o && sel_none_o));

  // R8
  none_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_none_o |-> $stable(last_q));

endmodule

// File: rtl/ipi_target_matcher.sv
module ipi_target_matcher #(
  parameter int N_UNITS = 16,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [31:0]        id_q,
  output logic [31:0]        lgc_q,
  output logic [31:0]        fmt_q,
  output logic [31:0]        cmdhi_q,
  input  logic [7:0]         msg_dest,
  input  logic               msg_logical,
  input  logic [1:0]         msg_short,
  input  logic               is_sender,
  output logic               match_o,
  output logic               fmt_err_o,
  input  logic               sel_req,
  input  logic [N_UNITS-1:0] cand_map,
  input  logic [N_UNITS-1:0] unit_en,
  output logic               sel_valid_o,
  output logic               sel_none_o,
  output logic [IW-1:0]      sel_idx_o
);

  target_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .id_q    (id_q),
    .lgc_q   (lgc_q),
    .fmt_q   (fmt_q),
    .cmdhi_q (cmdhi_q)
  );

  dest_match u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .dest         (msg_dest),
    .logical_mode (msg_logical),
    .short_code   (msg_short),
    .is_sender    (is_sender),
    .unit_id      (id_q[31:24]),
    .logical_id   (lgc_q[31:24]),
    .fmt_model    (fmt_q[31:28]),
    .match        (match_o),
    .fmt_err      (fmt_err_o)
  );

  rr_lowest_sel #(.N_UNITS(N_UNITS)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_req     (sel_req),
    .cand_map    (cand_map),
    .unit_en     (unit_en),
    .sel_valid_o (sel_valid_o),
    .sel_none_o  (sel_none_o),
    .sel_idx_o   (sel_idx_o)
  );

endmodule

// File: tb/test_ipi_target_matcher.sv
module test_ipi_target_matcher;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] id_q, lgc_q, fmt_q, cmdhi_q;
  logic [7:0] msg_dest = '0;
  logic msg_logical = 1'b0;
  logic [1:0] msg_short = '0;
  logic is_sender = 1'b0;
  logic match_o, fmt_err_o;
  logic sel_req = 1'b0;
  logic [N-1:0] cand_map = '0, unit_en = '0;
  logic sel_valid_o, sel_none_o;
  logic [IW-1:0] sel_idx_o;

  int checks = 0;
  int fails = 0;
  int last_m = N - 1;
  bit done = 0;

  always #5 clk = ~clk;

  ipi_target_matcher #(.N_UNITS(N)) i_ipi_target_matcher (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive_msg(input int d, input bit lg, input int sh, input bit snd);
    @(negedge clk);
    msg_dest = 8'(d); msg_logical = lg; msg_short = 2'(sh); is_sender = snd;
    #1;
  endtask

  task automatic do_sel(input logic [N-1:0] c, input logic [N-1:0] e);
    int exp_idx;
    bit exp_found;
    exp_found = 0; exp_idx = 0;
    for (int j = 1; j <= N; j++) begin
      int p;
      p = (last_m + j) % N;
      if (!exp_found && c[p] && e[p]) begin exp_found = 1; exp_idx = p; end
    end
    @(negedge clk);
    sel_req = 1'b1; cand_map = c; unit_en = e;
    @(negedge clk);
    sel_req = 1'b0;
    chk("R7 valid", 32'(sel_valid_o), 32'(exp_found));
    chk("R8 none", 32'(sel_none_o), 32'(!exp_found));
    if (exp_found) begin
      chk("R7 idx", 32'(sel_idx_o), 32'(exp_idx));
      last_m = exp_idx;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 id", id_q, 32'h0);
    chk("R9 lgc", lgc_q, 32'h0);
    chk("R9 fmt", fmt_q, 32'hFFFF_FFFF);
    chk("R9 cmdhi", cmdhi_q, 32'h0);
    chk("R9 valid", 32'(sel_valid_o), 0);
    chk("R9 none", 32'(sel_none_o), 0);

    // R6 write masking
    for (int k = 0; k < 6; k++) begin
      logic [31:0] v;
      v = 32'hA5C3_1E77 ^ (32'h1357_9BDF * k);
      wr(0, v); chk("R6 id", id_q, v & 32'hFF00_0000);
      wr(1, v); chk("R6 lgc", lgc_q, v & 32'hFF00_0000);
      wr(3, v); chk("R6 cmdhi", cmdhi_q, v & 32'hFF00_0000);
      wr(2, v); chk("R6 fmt", fmt_q, v | 32'h0FFF_FFFF);
    end

    // R1 physical sweep
    for (int idv = 0; idv < 256; idv += 51) begin
      wr(0, 32'(idv) << 24);
      for (int d = 0; d < 256; d++) begin
        drive_msg(d, 0, 0, d[0]);
        chk("R1 phys", 32'(match_o), 32'((d == 255) || (d == idv)));
        chk("R5 noerr", 32'(fmt_err_o), 0);
      end
    end

    // R2 flat sweep
    wr(2, 32'hF000_0000);
    for (int l = 0; l < 256; l += 37) begin
      wr(1, 32'(l) << 24);
      for (int d = 0; d < 256; d++) begin
        drive_msg(d, 1, 0, 0);
        chk("R2 flat", 32'(match_o), 32'((l & d) != 0));
      end
    end

    // R3 cluster sweep
    wr(2, 32'h0123_4567);
    for (int l = 3; l < 256; l += 29) begin
      wr(1, 32'(l) << 24);
      for (int d = 0; d < 256; d++) begin
        drive_msg(d, 1, 0, 0);
        chk("R3 cluster", 32'(match_o), 32'((l / 16 == d / 16) && (((l % 16) & (d % 16)) != 0)));
        chk("R5 noerr", 32'(fmt_err_o), 0);
      end
    end

    // R5 unknown formats
    wr(1, 32'hFF00_0000);
    for (int f = 1; f < 15; f++) begin
      wr(2, 32'(f) << 28);
      for (int d = 0; d < 256; d += 17) begin
        drive_msg(d, 1, 0, 0);
        chk("R5 match", 32'(match_o), 0);
        chk("R5 err", 32'(fmt_err_o), 1);
      end
    end

    // R4 shorthands, format still unknown, destination varied
    for (int sh = 1; sh < 4; sh++)
      for (int d = 0; d < 256; d += 15)
        for (int s = 0; s < 2; s++) begin
          drive_msg(d, d[0], sh, s[0]);
          chk("R4 short", 32'(match_o), 32'((sh == 2) || (sh == 1 && s == 1) || (sh == 3 && s == 0)));
          chk("R5 short noerr", 32'(fmt_err_o), 0);
        end

    // R7 full ring rotation, first pick is unit 0 (R9)
    for (int k = 0; k < N + 3; k++) do_sel('1, '1);
    // R8 skipping and empty cases
    do_sel('0, '1);
    do_sel('1, '0);
    do_sel(16'h8001, 16'h8001);
    do_sel(16'h8001, 16'h8001);
    do_sel(16'h0010, 16'hFFFF);
    do_sel(16'h0010, 16'hFFFF);
    for (int k = 0; k < 60; k++)
      do_sel(16'((k * 40503 + 7) ^ (k << 5)), 16'((k * 2654 + 3) ^ 16'h5A5A));
    do_sel('0, '0);
    do_sel(16'h0F00, 16'h0300);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule